// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Recognition

This block receives characters from an asynchronous serial line. A one-cycle enable, `tick_i`, marks sixteen sub-bit slots per bit time. The line first passes through a synchronizer. The receiver then waits for a falling edge. It confirms the start bit at mid-bit and shifts in either 8 or 9 data bits, least significant first. Each bit is decided by a majority vote of three samples taken near the middle of the bit.

A finished character goes into a holding register. A small set of sticky flags comes with it: receiver full, framing error, break, overrun and noise. A reception-in-progress flag follows the frame as it arrives. A frame whose data bits and stop bit are all zero is a break. A break still sets the framing error and full flags. It also sets a separate break flag and forces the held data to zero. The consumer pulses `rd_i` once it has taken a character. This clears the full flag and every error flag.

Top module: `uart_rx_brk`

## Requirements
- R1: Each bit is decided by a majority of three samples, taken in sub-bit slots 7, 8 and 9 after the detected start edge. Data arrives least significant bit first. With `len9_i`=0, a frame has 8 data bits and `bit9_o` reads 0. With `len9_i`=1, a frame has 9 data bits, and the last one is reported on `bit9_o`.
- R2: A falling edge starts a frame only if the voted start bit is 0. If the voted start bit is 1, the receiver returns to waiting for an edge, and no flag or data output changes.
- R3: When a frame completes with `full_o`=0, the received data is loaded into `data_o`/`bit9_o` and `full_o` is set.
- R4: `fe_o` is set when the voted stop bit is 0.
- R5: A frame whose stop bit and all of its 8 or 9 data bits are 0 is a break. A break sets `brk_o`, `fe_o` and `full_o`, and loads `data_o`=0 and `bit9_o`=0. A frame with stop bit 0 and any data bit at 1, the ninth bit included, sets `fe_o` but not `brk_o`.
- R6: `noise_o` is set when the three samples of any bit in the frame disagree, including the start and stop bits. The voted data is still delivered.
- R7: A frame that completes while `full_o`=1 sets `ovr_o`. It leaves `data_o`, `bit9_o`, `fe_o`, `brk_o` and `noise_o` unchanged, so a break is lost in this case too.
- R8: `rip_o` rises when a start bit is confirmed. It falls at the stop-bit decision.
- R9: A one-cycle `rd_i` clears `full_o`, `fe_o`, `brk_o`, `ovr_o` and `noise_o`. It leaves `data_o` and `bit9_o` as they were.
- R10: A line held low after a break starts no further frame. The line must first be seen high on a tick.
- R11: After reset, all flags and `data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling enable, 16 pulses per bit time |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| len9_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rd_i | input | 1 | Read strobe that clears full and error flags |
| data_o | output | 8 | Received data byte |
| bit9_o | output | 1 | Ninth received bit |
| full_o | output | 1 | Receiver full |
| fe_o | output | 1 | Framing error |
| brk_o | output | 1 | Break received |
| ovr_o | output | 1 | Overrun |
| noise_o | output | 1 | Sample disagreement within a frame |
| rip_o | output | 1 | Reception in progress |

## Verification
The bench sends a 9-bit frame that is zero except for its ninth bit, with stop bit 0. A receiver that ignores the ninth bit when testing for a break would flag it as a break. A break is also sent while a character is still unread. A design that let the break through during overrun would overwrite the held byte or set `brk_o`. A long low line after a break checks R10: a receiver that started on a level instead of an edge would restart and raise `ovr_o`. A one-slot glitch in a data bit and a short low pulse on an idle line check R6 and R2. A weak vote would corrupt the data in the first case, and a start check based on edge alone would report a character in the second.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_STOP
   } rx_state_e;

   typedef struct packed {
      logic fe;
      logic brk;
      logic noise;
   } frame_stat_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[0] <= 1'b1;
               else        chain_q[0] <= din;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[g] <= 1'b1;
               else        chain_q[g] <= chain_q[g-1];
         end
      end
   endgenerate

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rx_vote.sv
module rx_vote #(
   parameter int OS = 16,
   localparam int CW = $clog2(OS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          active,
   input  logic          line,
   input  logic [CW-1:0] sc,
   output logic          dec,
   output logic          bit_val,
   output logic          bit_noisy
);
   localparam int MID = OS / 2;
   localparam logic [CW-1:0] SLOT_A = CW'(MID - 1);
   localparam logic [CW-1:0] SLOT_B = CW'(MID);
   localparam logic [CW-1:0] SLOT_C = CW'(MID + 1);

   logic samp_a_q, samp_b_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         samp_a_q <= 1'b1;
         samp_b_q <= 1'b1;
      end else if (tick && active) begin
         if (sc == SLOT_A) samp_a_q <= line;
         if (sc == SLOT_B) samp_b_q <= line;
      end

   assign dec       = tick && active && (sc == SLOT_C);
   assign bit_val   = (samp_a_q & samp_b_q) | (samp_a_q & line) | (samp_b_q & line);
   assign bit_noisy = !((samp_a_q == samp_b_q) && (samp_b_q == line));
endmodule

// File: rtl/rx_frame.sv
module rx_frame
   import uart_rx_pkg::*;
#(
   parameter int OS     = 16,
   parameter int DATA_W = 8,
   localparam int CW    = $clog2(OS),
   localparam int BW    = $clog2(DATA_W + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line,
   input  logic              len9,
   input  logic              dec,
   input  logic              bit_val,
   input  logic              bit_noisy,
   output logic              active,
   output logic [CW-1:0]     sc,
   output logic              done,
   output frame_stat_t       stat,
   output logic [DATA_W-1:0] data,
   output logic              bit9,
   output logic              rip
);
   localparam logic [CW-1:0] SC_LAST = CW'(OS - 1);
   localparam logic [CW-1:0] SC_ONE  = CW'(1);

   rx_state_e       state;
   logic [BW-1:0]   bcnt;
   logic [BW-1:0]   nbits;
   logic [DATA_W:0] shreg;
   logic            any1, nacc, armed;

   assign nbits  = len9 ? BW'(DATA_W + 1) : BW'(DATA_W);
   assign active = (state != ST_IDLE);
   assign data   = len9 ? shreg[DATA_W-1:0] : shreg[DATA_W:1];
   assign bit9   = len9 & shreg[DATA_W];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         state <= ST_IDLE;
         sc    <= '0;
         bcnt  <= '0;
         shreg <= '0;
         any1  <= 1'b0;
         nacc  <= 1'b0;
         armed <= 1'b0;
         rip   <= 1'b0;
         done  <= 1'b0;
         stat  <= '0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            if (state == ST_IDLE) begin
               if (line) armed <= 1'b1;
               else if (armed) begin
                  state <= ST_START;
                  sc    <= SC_ONE;
                  armed <= 1'b0;
               end
            end else begin
               sc <= (sc == SC_LAST) ? '0 : sc + 1'b1;
               if (dec) begin
                  case (state)
                     ST_START: begin
                        if (bit_val) state <= ST_IDLE;
                        else begin
                           rip  <= 1'b1;
                           nacc <= bit_noisy;
                           any1 <= 1'b0;
                           bcnt <= '0;
                        end
                     end
                     ST_DATA: begin
                        shreg <= {bit_val, shreg[DATA_W:1]};
                        any1  <= any1 | bit_val;
                        nacc  <= nacc | bit_noisy;
                        bcnt  <= bcnt + 1'b1;
                     end
                     ST_STOP: begin
                        state      <= ST_IDLE;
                        rip        <= 1'b0;
                        done       <= 1'b1;
                        stat.fe    <= !bit_val;
                        stat.brk   <= !bit_val && !any1;
                        stat.noise <= nacc | bit_noisy;
                     end
                     default: ;
                  endcase
               end else if (sc == SC_LAST) begin
                  if (state == ST_START) state <= ST_DATA;
                  else if (state == ST_DATA && bcnt == nbits) state <= ST_STOP;
               end
            end
         end
      end

   // R8
   rip_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rip) |-> state == ST_START);
   // R8
   rip_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rip) |-> done);
endmodule

// File: rtl/rx_flags.sv
module rx_flags
   import uart_rx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic              done,
   input  frame_stat_t       stat,
   input  logic [DATA_W-1:0] din,
   input  logic              b9in,
   output logic [DATA_W-1:0] data,
   output logic              b9,
   output logic              full,
   output logic              fe,
   output logic              brk,
   output logic              ovr,
   output logic              noise
);
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         data  <= '0;
         b9    <= 1'b0;
         full  <= 1'b0;
         fe    <= 1'b0;
         brk   <= 1'b0;
         ovr   <= 1'b0;
         noise <= 1'b0;
      end else begin
         if (rd) begin
            full  <= 1'b0;
            fe    <= 1'b0;
            brk   <= 1'b0;
            ovr   <= 1'b0;
            noise <= 1'b0;
         end
         if (done) begin
            if (full && !rd) ovr <= 1'b1;
            else begin
               full  <= 1'b1;
               fe    <= stat.fe;
               brk   <= stat.brk;
               noise <= stat.noise;
               data  <= stat.brk ? '0 : din;
               b9    <= stat.brk ? 1'b0 : b9in;
            end
         end
      end

   // R5
   brk_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk |-> fe && full && data == '0 && !b9);
   // R7
   ovr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(full));
   // R9
   rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd && !done |=> !full && !fe && !brk && !ovr && !noise);
   // R3
   full_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full) |-> $past(done));
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
   import uart_rx_pkg::*;
#(
   parameter int OVERSAMPLE  = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              rxd_i,
   input  logic              len9_i,
   input  logic              rd_i,
   output logic [DATA_W-1:0] data_o,
   output logic              bit9_o,
   output logic              full_o,
   output logic              fe_o,
   output logic              brk_o,
   output logic              ovr_o,
   output logic              noise_o,
   output logic              rip_o
);
   localparam int CW = $clog2(OVERSAMPLE);

   generate
      if (OVERSAMPLE < 8) begin : g_bad_os
         $error("OVERSAMPLE must be at least 8");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_w
         $error("DATA_W must be positive");
      end
   endgenerate

   logic              line, active, dec, bit_val, bit_noisy, done, fr_b9;
   logic [CW-1:0]     sc;
   frame_stat_t       stat;
   logic [DATA_W-1:0] fr_data;

   rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .din(rxd_i), .dout(line));

   rx_vote #(.OS(OVERSAMPLE)) i_vote (
      .clk(clk), .rst_n(rst_n), .tick(tick_i), .active(active), .line(line),
      .sc(sc), .dec(dec), .bit_val(bit_val), .bit_noisy(bit_noisy));

   rx_frame #(.OS(OVERSAMPLE), .DATA_W(DATA_W)) i_frame (
      .clk(clk), .rst_n(rst_n), .tick(tick_i), .line(line), .len9(len9_i),
      .dec(dec), .bit_val(bit_val), .bit_noisy(bit_noisy), .active(active),
      .sc(sc), .done(done), .stat(stat), .data(fr_data), .bit9(fr_b9),
      .rip(rip_o));

   rx_flags #(.DATA_W(DATA_W)) i_flags (
      .clk(clk), .rst_n(rst_n), .rd(rd_i), .done(done), .stat(stat),
      .din(fr_data), .b9in(fr_b9), .data(data_o), .b9(bit9_o),
      .full(full_o), .fe(fe_o), .brk(brk_o), .ovr(ovr_o), .noise(noise_o));
endmodule

// File: tb/test_uart_rx_brk.sv
module test_uart_rx_brk;
   typedef struct packed {
      logic       len9;
      logic [8:0] bits;
      logic       stop;
      logic [3:0] gi;
      logic [7:0] xd;
      logic       xb9;
      logic       xfe;
      logic       xbrk;
      logic       xn;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 9'h0A5, 1'b1, 4'hF, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0},
      '{1'b0, 9'h000, 1'b1, 4'hF, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
      '{1'b1, 9'h1C3, 1'b1, 4'hF, 8'hC3, 1'b1, 1'b0, 1'b0, 1'b0},
      '{1'b0, 9'h000, 1'b0, 4'hF, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0},
      '{1'b1, 9'h000, 1'b0, 4'hF, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0},
      '{1'b0, 9'h081, 1'b0, 4'hF, 8'h81, 1'b0, 1'b1, 1'b0, 1'b0},
      '{1'b0, 9'h03C, 1'b1, 4'h2, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b1},
      '{1'b1, 9'h100, 1'b0, 4'hF, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0},
      '{1'b0, 9'h0FF, 1'b1, 4'hF, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic       len9 = 1'b0;
   logic       rd = 1'b0;
   logic [1:0] tcnt = 2'd0;
   logic       tick;
   logic [7:0] data_o;
   logic       bit9_o, full_o, fe_o, brk_o, ovr_o, noise_o, rip_o;
   int         tests = 0;
   int         fails = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) tcnt <= tcnt + 2'd1;
   assign tick = (tcnt == 2'd0);

   uart_rx_brk i_uart_rx_brk (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .rxd_i(rxd), .len9_i(len9),
      .rd_i(rd), .data_o(data_o), .bit9_o(bit9_o), .full_o(full_o),
      .fe_o(fe_o), .brk_o(brk_o), .ovr_o(ovr_o), .noise_o(noise_o),
      .rip_o(rip_o));

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic slot(input logic v);
      @(posedge clk iff tick);
      @(negedge clk);
      rxd = v;
   endtask

   task automatic drive_bit(input logic v, input logic glitch);
      for (int s = 0; s < 16; s++) slot((glitch && s == 8) ? ~v : v);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) slot(1'b1);
   endtask

   task automatic send(input logic l9, input logic [8:0] bits,
                       input logic stop, input logic [3:0] gi);
      len9 = l9;
      drive_bit(1'b0, 1'b0);
      for (int i = 0; i < (l9 ? 9 : 8); i++) drive_bit(bits[i], gi == 4'(i));
      drive_bit(stop, 1'b0);
   endtask

   task automatic read_pulse();
      @(negedge clk) rd = 1'b1;
      @(negedge clk) rd = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11", "data", data_o, 8'h00);
      check("R11", "flags", {2'b0, bit9_o, full_o, fe_o, brk_o, ovr_o, noise_o}, 8'h00);
      check("R11", "rip", {7'b0, rip_o}, 8'h00);
      idle(8);

      // R2 short low pulse on idle line must not start a frame
      for (int k = 0; k < 4; k++) slot(1'b0);
      idle(30);
      check("R2", "full after glitch", {7'b0, full_o}, 8'h00);
      check("R2", "rip after glitch", {7'b0, rip_o}, 8'h00);

      // table of frames, read after each (R1 R3 R4 R5 R6 R9)
      for (int v = 0; v < NV; v++) begin
         send(VECS[v].len9, VECS[v].bits, VECS[v].stop, VECS[v].gi);
         idle(4);
         check("R1", "data", data_o, VECS[v].xd);
         check("R1", "bit9", {7'b0, bit9_o}, {7'b0, VECS[v].xb9});
         check("R3", "full", {7'b0, full_o}, 8'h01);
         check("R4", "fe", {7'b0, fe_o}, {7'b0, VECS[v].xfe});
         check("R5", "brk", {7'b0, brk_o}, {7'b0, VECS[v].xbrk});
         check("R6", "noise", {7'b0, noise_o}, {7'b0, VECS[v].xn});
         check("R7", "no ovr", {7'b0, ovr_o}, 8'h00);
         read_pulse();
         check("R9", "flags cleared", {3'b0, full_o, fe_o, brk_o, ovr_o, noise_o}, 8'h00);
         check("R9", "data kept", data_o, VECS[v].xd);
      end

      // R8 reception in progress during a frame
      len9 = 1'b0;
      drive_bit(1'b0, 1'b0);
      drive_bit(1'b1, 1'b0);
      check("R8", "rip mid frame", {7'b0, rip_o}, 8'h01);
      for (int i = 1; i < 8; i++) drive_bit(1'b0, 1'b0);
      drive_bit(1'b1, 1'b0);
      idle(2);
      check("R8", "rip after stop", {7'b0, rip_o}, 8'h00);
      check("R8", "frame data", data_o, 8'h01);
      read_pulse();

      // R7 overrun: second frame while full is dropped
      send(1'b0, 9'h011, 1'b1, 4'hF);
      idle(4);
      send(1'b0, 9'h022, 1'b1, 4'hF);
      idle(4);
      check("R7", "ovr set", {7'b0, ovr_o}, 8'h01);
      check("R7", "data kept", data_o, 8'h11);
      check("R7", "full kept", {7'b0, full_o}, 8'h01);
      // R7 break while full is dropped too
      send(1'b0, 9'h000, 1'b0, 4'hF);
      idle(4);
      check("R7", "brk not set", {7'b0, brk_o}, 8'h00);
      check("R7", "fe not set", {7'b0, fe_o}, 8'h00);
      check("R7", "data after break", data_o, 8'h11);
      read_pulse();
      check("R9", "ovr cleared", {7'b0, ovr_o}, 8'h00);

      // R10 held break line does not retrigger
      send(1'b0, 9'h000, 1'b0, 4'hF);
      for (int k = 0; k < 48; k++) slot(1'b0);
      idle(8);
      check("R10", "brk", {7'b0, brk_o}, 8'h01);
      check("R10", "no ovr", {7'b0, ovr_o}, 8'h00);
      check("R10", "rip idle", {7'b0, rip_o}, 8'h00);
      read_pulse();

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule